// File: doc/BRIEF.md
# Ingress Credit Policer with Pause Hysteresis and Banded Random Drop

This block judges each received frame on one port against the credit level that the port's rate bucket reports. It also compares that credit with the configured maximum burst. The bucket itself, frame classification and the building of pause frames all live elsewhere. The block only reads the credit, the burst limit and a pair of drop percentages, and it produces per-frame verdicts and pause requests.

With flow control switched on, the block keeps every frame. It keeps one bit of pause state. It emits a single-cycle stop request when credit falls below half of the maximum burst, and a single-cycle resume request when credit climbs back above that level. With flow control switched off, it makes a weighted random early drop decision for each frame, using three credit bands:

- empty credit;
- credit at or below a quarter of the burst;
- credit at or below half of the burst.

Frames are marked either high-drop or low-drop, and the two markings are treated differently. A 16-bit LFSR supplies the random number, scaled into the range 0..99.

Top module: `ingress_credit_policer`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, verdict_valid, verdict_drop, xoff_pulse and xon_pulse are all 0.
- R2: With fc_en high and the pause state clear, a credit strictly below max_burst>>1 sets the pause state. xoff_pulse is 1 for exactly the one cycle after the edge that sampled the condition. No further xoff_pulse follows while the state stays set.
- R3: With fc_en high and the pause state set, a credit strictly above max_burst>>1 clears the state and gives a single-cycle xon_pulse. A credit equal to max_burst>>1 leaves the state unchanged and gives no pulse.
- R4: Whenever fc_en is low, the pause state is cleared, and no xoff_pulse or xon_pulse is produced. After fc_en is raised again, a low credit produces a fresh xoff_pulse.
- R5: A frame_start sampled at a clock edge gives verdict_valid=1 for exactly the next cycle, together with verdict_drop. With fc_en high, verdict_drop is 0.
- R6: With fc_en low and credit equal to 0, every frame is dropped, whatever its marking.
- R7: With fc_en low and 0 < credit <= max_burst>>2, a high-drop frame (frame_high_drop=1) is always dropped. A low-drop frame is dropped when the scaled random value is less than rate_a.
- R8: With fc_en low and max_burst>>2 < credit <= max_burst>>1, a high-drop frame is dropped when the scaled random value is less than rate_b. A low-drop frame is always accepted.
- R9: With fc_en low and credit > max_burst>>1, no frame is dropped.
- R10: The random source behaves as follows:
  - Reset value: 16'hACE1.
  - Step rule: on each sampled frame_start the LFSR shifts left, taking in bit l[15]^l[13]^l[12]^l[10].
  - Which value decides: the decision for a frame uses the value held before that step.
  - Scaling: the value is scaled as (l*100)>>16.
  - Rates: rate_a and rate_b are 7-bit percentages, and any value of 100 or above drops every candidate frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_en | input | 1 | Ingress flow control enable |
| credit | input | CREDIT_W | Current credit from the rate bucket |
| max_burst | input | CREDIT_W | Maximum burst credit |
| rate_a | input | 7 | Low-drop drop percentage in the quarter band |
| rate_b | input | 7 | High-drop drop percentage in the half band |
| frame_start | input | 1 | One-cycle strobe for a new received frame |
| frame_high_drop | input | 1 | Drop-precedence marking of that frame |
| verdict_valid | output | 1 | Verdict strobe, one cycle after frame_start |
| verdict_drop | output | 1 | 1 means the frame is discarded |
| xoff_pulse | output | 1 | Single-cycle stop request |
| xon_pulse | output | 1 | Single-cycle resume request |

## Verification
A frame verdict and a pause transition can appear in the same cycle. This happens when frame_start arrives in the cycle in which the credit crosses half of the burst with flow control on. The resulting cycle must then show verdict_valid with no drop, alongside exactly one xoff_pulse or xon_pulse. The bench provokes this overlap in directed steps and also through random stimulus that toggles fc_en and moves credit across both band edges. Each cycle is compared against a reference model of the pause bit, the bands and the LFSR.

// File: rtl/ingress_credit_policer.sv
module ingress_credit_policer #(
  parameter int CREDIT_W = 24,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fc_en,
  input  logic [CREDIT_W-1:0] credit,
  input  logic [CREDIT_W-1:0] max_burst,
  input  logic [6:0]          rate_a,
  input  logic [6:0]          rate_b,
  input  logic                frame_start,
  input  logic                frame_high_drop,
  output logic                verdict_valid,
  output logic                verdict_drop,
  output logic                xoff_pulse,
  output logic                xon_pulse
);

  localparam int PROD_W = 16 + 7;

  logic [CREDIT_W-1:0] half_lvl, quarter_lvl;
  logic below_half, above_half, in_quarter, in_half, empty;
  logic paused;
  logic [15:0] lfsr;
  logic [PROD_W-1:0] prod;
  logic [6:0] pick;
  logic hit_a, hit_b, drop_now;

  assign half_lvl    = max_burst >> 1;
  assign quarter_lvl = max_burst >> 2;
  assign below_half  = credit < half_lvl;
  assign above_half  = credit > half_lvl;
  assign empty       = credit == '0;
  assign in_quarter  = !empty && credit <= quarter_lvl;
  assign in_half     = credit > quarter_lvl && !above_half;

  // pause hysteresis
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      paused     <= 1'b0;
      xoff_pulse <= 1'b0;
      xon_pulse  <= 1'b0;
    end else begin
      xoff_pulse <= fc_en && !paused && below_half;
      xon_pulse  <= fc_en && paused && above_half;
      if (!fc_en)                     paused <= 1'b0;
      else if (!paused && below_half) paused <= 1'b1;
      else if (paused && above_half)  paused <= 1'b0;
    end
  end

  // random source scaled into 0..99
  assign prod  = PROD_W'(lfsr) * PROD_W'(100);
  assign pick  = prod[PROD_W-1:16];
  assign hit_a = pick < rate_a;
  assign hit_b = pick < rate_b;

  always_comb begin
    drop_now = 1'b0;
    if (!fc_en) begin
      if (empty)           drop_now = 1'b1;
      else if (in_quarter) drop_now = frame_high_drop ? 1'b1 : hit_a;
      else if (in_half)    drop_now = frame_high_drop ? hit_b : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr          <= LFSR_SEED;
      verdict_valid <= 1'b0;
      verdict_drop  <= 1'b0;
    end else begin
      verdict_valid <= frame_start;
      verdict_drop  <= frame_start && drop_now;
      if (frame_start)
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  p_pulse_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(xoff_pulse && xon_pulse));
  p_xoff_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_pulse |=> !xoff_pulse);
  p_hold_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && credit == half_lvl) |=> !xoff_pulse && !xon_pulse);
  p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> !xoff_pulse && !xon_pulse);
  p_verdict_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> verdict_valid);
  p_drop_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_drop |-> verdict_valid);
  p_fc_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && fc_en) |=> !verdict_drop);
  p_empty_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fc_en && credit == '0) |=> verdict_drop);
  p_quarter_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fc_en && frame_high_drop && credit <= quarter_lvl) |=> verdict_drop);
  p_half_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fc_en && !frame_high_drop && credit > quarter_lvl) |=> !verdict_drop);
  p_above_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fc_en && credit > half_lvl) |=> !verdict_drop);

endmodule

// File: tb/sim_ingress_credit_policer.sv
module sim_ingress_credit_policer;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fc_en = 1'b0;
  logic [CW-1:0] credit = '0;
  logic [CW-1:0] max_burst = '0;
  logic [6:0] rate_a = '0;
  logic [6:0] rate_b = '0;
  logic frame_start = 1'b0;
  logic frame_high_drop = 1'b0;
  logic verdict_valid, verdict_drop, xoff_pulse, xon_pulse;

  int checks = 0;
  int fails = 0;
  logic m_paused = 1'b0;
  logic [15:0] m_lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  ingress_credit_policer #(.CREDIT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .credit(credit),
    .max_burst(max_burst), .rate_a(rate_a), .rate_b(rate_b),
    .frame_start(frame_start), .frame_high_drop(frame_high_drop),
    .verdict_valid(verdict_valid), .verdict_drop(verdict_drop),
    .xoff_pulse(xoff_pulse), .xon_pulse(xon_pulse));

  function automatic logic [6:0] scaled(input logic [15:0] l);
    logic [22:0] p;
    p = {7'd0, l} * 23'd100;
    return p[22:16];
  endfunction

  // R6 R7 R8 R9 band rules
  function automatic logic exp_drop(input logic fc, input logic [CW-1:0] c,
                                    input logic [CW-1:0] mb, input logic hd,
                                    input logic [6:0] ra, input logic [6:0] rb,
                                    input logic [15:0] l);
    if (fc) return 1'b0;
    if (c == 0) return 1'b1;
    if (c <= (mb >> 2)) return hd ? 1'b1 : (scaled(l) < ra);
    if (c <= (mb >> 1)) return hd ? (scaled(l) < rb) : 1'b0;
    return 1'b0;
  endfunction

  function automatic string band_tag(input logic fc, input logic [CW-1:0] c,
                                     input logic [CW-1:0] mb);
    if (fc) return "R5";
    if (c == 0) return "R6";
    if (c <= (mb >> 2)) return "R7/R10";
    if (c <= (mb >> 1)) return "R8/R10";
    return "R9";
  endfunction

  // one cycle: predict from current inputs, advance, compare
  task automatic step(input string tag);
    logic e_v, e_d, e_xoff, e_xon;
    string vt;
    e_xoff = fc_en && !m_paused && (credit < (max_burst >> 1));
    e_xon  = fc_en && m_paused && (credit > (max_burst >> 1));
    e_v    = frame_start;
    e_d    = frame_start && exp_drop(fc_en, credit, max_burst, frame_high_drop,
                                     rate_a, rate_b, m_lfsr);
    vt = band_tag(fc_en, credit, max_burst);
    if (!fc_en) m_paused = 1'b0;
    else if (e_xoff) m_paused = 1'b1;
    else if (e_xon) m_paused = 1'b0;
    if (frame_start)
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    @(negedge clk);
    checks++;
    if ({xoff_pulse, xon_pulse} !== {e_xoff, e_xon}) begin
      fails++;
      $display("FAIL %s pause: xoff/xon=%b%b expected %b%b", tag, xoff_pulse, xon_pulse, e_xoff, e_xon);
    end
    if ({verdict_valid, verdict_drop} !== {e_v, e_d}) begin
      fails++;
      $display("FAIL %s %s verdict: valid/drop=%b%b expected %b%b", tag, vt,
               verdict_valid, verdict_drop, e_v, e_d);
    end
  endtask

  task automatic frame(input logic hd, input string tag);
    frame_start = 1'b1;
    frame_high_drop = hd;
    step(tag);
    frame_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7341));
    max_burst = 24'd1000;
    rate_a = 7'd40;
    rate_b = 7'd60;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    checks++;
    if ({verdict_valid, verdict_drop, xoff_pulse, xon_pulse} !== 4'b0) begin
      fails++;
      $display("FAIL R1 reset outputs=%b expected 0000",
               {verdict_valid, verdict_drop, xoff_pulse, xon_pulse});
    end
    rst_n = 1'b1;
    credit = 24'd900;
    step("R1");

    // R2 R3: hysteresis with overlapping frames
    fc_en = 1'b1;
    step("R2");
    credit = 24'd499;
    frame(1'b1, "R2/R5");
    step("R2");
    credit = 24'd500;
    step("R3");
    credit = 24'd501;
    frame(1'b0, "R3/R5");
    step("R3");
    credit = 24'd10;
    step("R2");
    // R4: disable clears, re-enable re-arms
    fc_en = 1'b0;
    step("R4");
    step("R4");
    fc_en = 1'b1;
    step("R4");
    fc_en = 1'b0;
    step("R4");

    // R6 R7 R8 R9 directed band edges
    credit = 0;       frame(1'b0, "R6"); frame(1'b1, "R6");
    credit = 250;     frame(1'b1, "R7"); frame(1'b0, "R7");
    credit = 1;       frame(1'b0, "R7");
    credit = 251;     frame(1'b0, "R8"); frame(1'b1, "R8");
    credit = 500;     frame(1'b1, "R8");
    credit = 501;     frame(1'b1, "R9"); frame(1'b0, "R9");
    // R10: rate 100 and above drop every candidate, 0 none
    rate_a = 7'd100; rate_b = 7'd127;
    credit = 100; repeat (4) frame(1'b0, "R10");
    credit = 400; repeat (4) frame(1'b1, "R10");
    rate_a = 7'd0; rate_b = 7'd0;
    credit = 100; repeat (4) frame(1'b0, "R10");
    credit = 400; repeat (4) frame(1'b1, "R10");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 15) == 0) fc_en = ~fc_en;
      if ($urandom_range(0, 31) == 0) max_burst = CW'($urandom_range(0, 4000));
      if ($urandom_range(0, 31) == 0) rate_a = 7'($urandom_range(0, 110));
      if ($urandom_range(0, 31) == 0) rate_b = 7'($urandom_range(0, 110));
      case ($urandom_range(0, 4))
        0: credit = 0;
        1: credit = max_burst >> 2;
        2: credit = max_burst >> 1;
        3: credit = (max_burst >> 1) + 1;
        default: credit = CW'($urandom_range(0, 4200));
      endcase
      frame_start = $urandom_range(0, 1);
      frame_high_drop = $urandom_range(0, 1);
      step("R2/R3/R4");
    end
    frame_start = 1'b0;
    step("R5");
    finish_run();
  end
endmodule